// File: doc/BRIEF.md
# Oversampled Serial Word Receiver

This block takes one single-ended serial line, for example the output of a differential input buffer, and turns it into 32-bit words. The system clock samples the line four times per bit period. The receiver looks for a two-half start pattern, recovers the payload, and checks the parity bit and the stop bit. Each accepted word appears on the data output together with a one-cycle valid strobe. A frame that fails its checks raises a one-cycle error pulse instead.

A line whose far end is unconnected tends to float and produce random edges. The receiver guards against this with a link-health tracker. A run of consecutive bad frames switches the channel off, and no words are delivered while it is off. The channel switches back on only after the line has stayed high without a break for a long idle interval. Downstream logic can then store only words from healthy channels.

Top module: `serial_word_rx`

## Requirements
- R1: After reset, link_ok_o is 1, valid_o, parity_err_o and stop_err_o are 0, and data_o is all zeros.
- R2: The line idles high. Every bit lasts exactly 4 clock cycles. A frame is sent in this order: a low start half, a high start half, 32 data bits with the least significant bit first, a parity bit, and a stop bit that must be high. A correct frame loads data_o and raises valid_o for one cycle.
- R3: The low start half must be sampled low on 4 consecutive cycles, and the high start half must then be sampled high on the next 4 cycles. A low pulse shorter than 4 cycles starts nothing. A low that arrives during the high half restarts the low-half count.
- R4: Parity is even by default: the parity bit equals the XOR of the 32 data bits. On a mismatch, parity_err_o pulses for one cycle, valid_o stays 0 and data_o keeps its previous value.
- R5: If the stop bit is sampled low, stop_err_o pulses for one cycle, valid_o stays 0 and data_o keeps its previous value.
- R6: valid_o, parity_err_o and stop_err_o are single-cycle pulses.
- R7: link_ok_o falls in the same cycle as the error pulse of the 4th consecutive bad frame. Any correct frame clears the run of bad frames.
- R8: While link_ok_o is 0, valid_o stays 0, even for correct frames.
- R9: A disabled channel sets link_ok_o to 1 again once the synchronized line has been high for 1024 consecutive cycles (256 bit periods). Any low sample restarts that count.
- R10: valid_o never coincides with parity_err_o or stop_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, 4 cycles per bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | 32 | Last accepted word |
| valid_o | output | 1 | One-cycle strobe for a new word |
| parity_err_o | output | 1 | One-cycle pulse for a parity failure |
| stop_err_o | output | 1 | One-cycle pulse for a low stop bit |
| link_ok_o | output | 1 | Channel enabled |

## Verification
The bench drives a 3-cycle low glitch, which a receiver that does not count the full low half would treat as a start. It also drives a high start half that is cut short by a new low, which a receiver that does not realign would decode as a shifted, corrupted word. The link tracker is tested with three bad frames, one good frame and three more bad frames; a tracker that counts all bad frames instead of consecutive ones would wrongly disable the channel. The bench then checks that the link is still down after 900 high cycles and back up after 1100, which exposes a wrong idle count or an idle count that a frame does not reset. It also checks that data_o keeps the last good word across bad frames.

// File: rtl/serial_word_rx_pkg.sv
package serial_word_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT,
    ST_LOW,
    ST_HIGH,
    ST_BITS
  } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  // reset to idle-high so no false start after reset
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b1;
          else         sync_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b1;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_word_rx_pkg::*;
#(
  parameter int  DATA_W     = 32,
  parameter int  OS         = 4,
  parameter int  SAMPLE_PH  = 2,
  parameter bit  ODD_PARITY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              done_o,
  output logic              par_ok_o,
  output logic              stop_ok_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int CNT_W    = (OS > 2) ? $clog2(OS) : 1;
  localparam int IDX_W    = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_SMP  = CNT_W'(SAMPLE_PH);
  localparam logic [IDX_W-1:0] IDX_PAR  = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(DATA_W + 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_bit_q;
  logic              at_sample;

  assign at_sample = (state_q == ST_BITS) && (cnt_q == CNT_SMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      cnt_q     <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      par_bit_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_HUNT: begin
          if (!line_i) begin
            state_q <= ST_LOW;
            cnt_q   <= CNT_ONE;
          end
        end
        ST_LOW: begin
          if (line_i) begin
            state_q <= ST_HUNT;
          end else if (cnt_q == CNT_LAST) begin
            state_q <= ST_HIGH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        ST_HIGH: begin
          // a low here may be the first low of a real start: realign
          if (!line_i) begin
            state_q <= ST_LOW;
            cnt_q   <= CNT_ONE;
          end else if (cnt_q == CNT_LAST) begin
            state_q <= ST_BITS;
            cnt_q   <= '0;
            idx_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        ST_BITS: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
          if (at_sample) begin
            if (idx_q < IDX_PAR) shift_q <= {line_i, shift_q[DATA_W-1:1]};
            if (idx_q == IDX_PAR) par_bit_q <= line_i;
            if (idx_q == IDX_STOP) begin
              state_q <= ST_HUNT;
              cnt_q   <= '0;
            end
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign done_o    = at_sample && (idx_q == IDX_STOP);
  assign stop_ok_o = line_i;
  assign par_ok_o  = ((^shift_q) ^ par_bit_q) == ODD_PARITY;
  assign word_o    = shift_q;
endmodule

// File: rtl/rx_link_guard.sv
module rx_link_guard #(
  parameter int OS        = 4,
  parameter int BAD_LIMIT = 4,
  parameter int IDLE_BITS = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic done_i,
  input  logic bad_i,
  output logic link_ok_o
);
  localparam int IDLE_CYC = IDLE_BITS * OS;
  localparam int BAD_W    = $clog2(BAD_LIMIT + 1);
  localparam int IDLE_W   = $clog2(IDLE_CYC + 1);
  localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(BAD_LIMIT - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYC - 1);

  logic [BAD_W-1:0]  bad_q;
  logic [IDLE_W-1:0] idle_q;
  logic              link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_q  <= '0;
      idle_q <= '0;
      link_q <= 1'b1;
    end else if (link_q) begin
      idle_q <= '0;
      if (done_i) begin
        if (!bad_i) begin
          bad_q <= '0;
        end else if (bad_q == BAD_LAST) begin
          bad_q  <= '0;
          link_q <= 1'b0;
        end else begin
          bad_q <= bad_q + 1'b1;
        end
      end
    end else begin
      bad_q <= '0;
      if (!line_i) begin
        idle_q <= '0;
      end else if (idle_q == IDLE_LAST) begin
        idle_q <= '0;
        link_q <= 1'b1;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign link_ok_o = link_q;
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int DATA_W      = 32,
  parameter int OS          = 4,
  parameter int SAMPLE_PH   = 2,
  parameter int SYNC_STAGES = 2,
  parameter bit ODD_PARITY  = 1'b0,
  parameter int BAD_LIMIT   = 4,
  parameter int IDLE_BITS   = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              parity_err_o,
  output logic              stop_err_o,
  output logic              link_ok_o
);
  logic              line_s;
  logic              done;
  logic              par_ok;
  logic              stop_ok;
  logic [DATA_W-1:0] word;
  logic              link_ok;
  logic              accept;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  rx_framer #(
    .DATA_W    (DATA_W),
    .OS        (OS),
    .SAMPLE_PH (SAMPLE_PH),
    .ODD_PARITY(ODD_PARITY)
  ) u_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_s),
    .done_o   (done),
    .par_ok_o (par_ok),
    .stop_ok_o(stop_ok),
    .word_o   (word)
  );

  rx_link_guard #(
    .OS       (OS),
    .BAD_LIMIT(BAD_LIMIT),
    .IDLE_BITS(IDLE_BITS)
  ) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_s),
    .done_i   (done),
    .bad_i    (!(par_ok && stop_ok)),
    .link_ok_o(link_ok)
  );

  assign accept = done && par_ok && stop_ok && link_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o       <= '0;
      valid_o      <= 1'b0;
      parity_err_o <= 1'b0;
      stop_err_o   <= 1'b0;
    end else begin
      valid_o      <= accept;
      parity_err_o <= done && !par_ok;
      stop_err_o   <= done && !stop_ok;
      if (accept) data_o <= word;
    end
  end

  assign link_ok_o = link_ok;
endmodule

// File: rtl/serial_word_rx_checker.sv
module serial_word_rx_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_s,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              parity_err_o,
  input logic              stop_err_o,
  input logic              link_ok_o
);
  a_r6_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r6_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_err_o || stop_err_o) |=> !(parity_err_o || stop_err_o));
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(parity_err_o || stop_err_o));
  a_r8_no_valid_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_ok_o |-> !valid_o);
  a_r7_drop_on_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_ok_o) |-> (parity_err_o || stop_err_o));
  a_r9_rise_on_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_ok_o) |-> $past(line_s));
  a_r4_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

bind serial_word_rx serial_word_rx_checker #(.DATA_W(DATA_W)) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_s      (line_s),
  .data_o      (data_o),
  .valid_o     (valid_o),
  .parity_err_o(parity_err_o),
  .stop_err_o  (stop_err_o),
  .link_ok_o   (link_ok_o)
);

// File: tb/serial_word_rx_bench.sv
module serial_word_rx_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_i = 1'b1;
  logic [31:0] data_o;
  logic        valid_o, parity_err_o, stop_err_o, link_ok_o;

  int n_checks = 0;
  int n_errors = 0;
  int n_valid = 0, n_perr = 0, n_serr = 0;
  bit done_flag = 1'b0;

  always #2 clk_i = ~clk_i;

  serial_word_rx u_serial_word_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (line_i),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .parity_err_o(parity_err_o),
    .stop_err_o  (stop_err_o),
    .link_ok_o   (link_ok_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o)      n_valid++;
      if (parity_err_o) n_perr++;
      if (stop_err_o)   n_serr++;
    end
  end

  // {bad_parity, bad_stop, word}
  localparam logic [33:0] VEC [8] = '{
    {2'b00, 32'hA5A5_0F3C},
    {2'b00, 32'h0000_0000},
    {2'b00, 32'hFFFF_FFFF},
    {2'b10, 32'h1234_5678},
    {2'b00, 32'h8000_0001},
    {2'b01, 32'hDEAD_BEEF},
    {2'b11, 32'h0000_0001},
    {2'b00, 32'h7FFF_FFFE}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    line_i = v;
    repeat (n) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic send_frame(input logic [31:0] w, input bit bad_par, input bit bad_stop);
    hold(1'b0, 4);
    hold(1'b1, 4);
    for (int i = 0; i < 32; i++) hold(w[i], 4);
    hold((^w) ^ bad_par, 4);
    hold(!bad_stop, 4);
    hold(1'b1, 8);
  endtask

  task automatic expect_counts(input string req, input int v0, input int p0, input int s0,
                               input int dv, input int dp, input int ds);
    chk(n_valid - v0 == dv, req, 32'(n_valid - v0), 32'(dv));
    chk(n_perr - p0 == dp, req, 32'(n_perr - p0), 32'(dp));
    chk(n_serr - s0 == ds, req, 32'(n_serr - s0), 32'(ds));
  endtask

  initial begin
    #1000000;
    if (!done_flag) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_good;
    int v0, p0, s0;
    repeat (3) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    hold(1'b1, 4);
    // R1 reset state
    chk(link_ok_o == 1'b1, "R1 link_ok", 32'(link_ok_o), 32'd1);
    chk(data_o == 32'd0, "R1 data", data_o, 32'd0);
    chk({valid_o, parity_err_o, stop_err_o} == 3'b000, "R1 pulses",
        32'({valid_o, parity_err_o, stop_err_o}), 32'd0);

    // table: R2 good frames, R4 parity, R5 stop, R10 exclusivity
    last_good = 32'd0;
    for (int k = 0; k < 8; k++) begin
      logic bp, bs;
      bp = VEC[k][33];
      bs = VEC[k][32];
      v0 = n_valid; p0 = n_perr; s0 = n_serr;
      send_frame(VEC[k][31:0], bp, bs);
      if (!bp && !bs) last_good = VEC[k][31:0];
      expect_counts(bp ? "R4 parity" : (bs ? "R5 stop" : "R2 frame"), v0, p0, s0,
                    (!bp && !bs) ? 1 : 0, bp ? 1 : 0, bs ? 1 : 0);
      chk(data_o == last_good, "R2/R4/R5 data_o", data_o, last_good);
      chk(link_ok_o == 1'b1, "R7 link stays up", 32'(link_ok_o), 32'd1);
    end

    // R3 short low glitch starts nothing
    v0 = n_valid; p0 = n_perr; s0 = n_serr;
    hold(1'b0, 3);
    hold(1'b1, 200);
    expect_counts("R3 glitch", v0, p0, s0, 0, 0, 0);

    // R3 truncated high half realigns on next low
    v0 = n_valid; p0 = n_perr; s0 = n_serr;
    hold(1'b0, 4);
    hold(1'b1, 3);
    send_frame(32'hC001_D00D, 1'b0, 1'b0);
    expect_counts("R3 realign", v0, p0, s0, 1, 0, 0);
    chk(data_o == 32'hC001_D00D, "R3 realign data", data_o, 32'hC001_D00D);

    // R3 long low before the high half
    v0 = n_valid;
    hold(1'b0, 8);
    send_frame(32'h0BAD_F00D, 1'b0, 1'b0);
    chk(n_valid - v0 == 1, "R3 long low", 32'(n_valid - v0), 32'd1);
    chk(data_o == 32'h0BAD_F00D, "R3 long low data", data_o, 32'h0BAD_F00D);

    // R7 run broken by a good frame
    for (int k = 0; k < 3; k++) send_frame(32'h5555_AAAA, 1'b1, 1'b0);
    chk(link_ok_o == 1'b1, "R7 after 3 bad", 32'(link_ok_o), 32'd1);
    send_frame(32'h1111_2222, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) send_frame(32'h3333_4444, 1'b0, 1'b1);
    chk(link_ok_o == 1'b1, "R7 run reset", 32'(link_ok_o), 32'd1);
    send_frame(32'h3333_4444, 1'b1, 1'b0);
    chk(link_ok_o == 1'b0, "R7 drop on 4th", 32'(link_ok_o), 32'd0);

    // R8 good frame while disabled is not delivered
    v0 = n_valid;
    send_frame(32'h600D_600D, 1'b0, 1'b0);
    chk(n_valid == v0, "R8 no valid", 32'(n_valid - v0), 32'd0);
    chk(data_o == 32'h1111_2222, "R8 data held", data_o, 32'h1111_2222);

    // R9 re-enable after 1024 high cycles
    hold(1'b1, 900);
    chk(link_ok_o == 1'b0, "R9 still down", 32'(link_ok_o), 32'd0);
    hold(1'b1, 200);
    chk(link_ok_o == 1'b1, "R9 back up", 32'(link_ok_o), 32'd1);
    v0 = n_valid;
    send_frame(32'hFACE_0001, 1'b0, 1'b0);
    chk(n_valid - v0 == 1, "R9 delivers again", 32'(n_valid - v0), 32'd1);
    chk(data_o == 32'hFACE_0001, "R9 data", data_o, 32'hFACE_0001);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule